// File: doc/BRIEF.md
# Video Encoder Timing Generator

This block produces the line and field timing for a standard-definition digital video encoder. A pixel counter runs across each line. Its length is set by the selected line rate: 1728 clocks at 50 Hz and 1716 clocks at 60 Hz with the default parameters. A second counter steps in half-lines and spans one field. The field is either a true interlaced field, which carries an extra half-line, or one of two progressive lengths. Interlaced fields alternate between starting at the start of a line and starting in the middle of a line. A field-parity flag toggles on each interlaced field.

An external sync pulse realigns both counters at once. The programmed horizontal and vertical trigger phases set the value each counter is loaded with, so a larger trigger value brings the generated timing sooner after the sync. The vertical trigger carries a sign bit that turns it into a lag.

A one-clock pulse for resetting the colour subcarrier phase is produced at one of three cadences, or not at all. A configuration bit forces the encoder output to blanking level. All settings are written through a byte-wide parallel write port.

Top module: `enc_timing_gen`

## Requirements
- R1: With no sync pulse, `hsync_o` rises once every LINE_50 clocks when rate bit 6 of the mode register is 0, and once every LINE_60 clocks when it is 1. `h_cnt_o` counts 0 up to the line length minus 1, and `hsync_o` is high while it is 0.
- R2: The field length in half-lines is set by mode bits [3:2]. Code 0 gives 2N+1, code 1 gives 2N, and codes 2 and 3 give 2N+2, where N is LINES_50 or LINES_60 according to the rate bit. `vsync_o` therefore rises once every field-length × line-length / 2 clocks.
- R3: With code 0, `field_o` toggles at each `vsync_o`, and successive `vsync_o` pulses fall at pixel positions that differ by half a line. With any other code, `field_o` is 0 at every `vsync_o`, and every `vsync_o` falls at the same pixel position.
- R4: An `ext_sync_i` pulse loads the pixel counter with the horizontal trigger value, clamped to the line length minus 1. The trigger is register 0 bits [7:0] plus register 1 bits [2:0] as bits [10:8]. `hsync_o` is first seen 1 + (line_length − trigger) mod line_length clocks after the capturing edge, counting that edge as 1.
- R5: The same pulse loads the half-line counter. The vertical trigger is register 1 bits [7:3], clamped to the field length minus 1. Mode bit 0 = 0 loads the trigger value itself; mode bit 0 = 1 loads the field length minus the trigger (0 stays 0). Loading 0 raises `vsync_o` right after the capturing edge. A larger positive value brings the next `vsync_o` sooner.
- R6: Mode bits [5:4] select the subcarrier reset. Code 0 never pulses `sc_rst_o`. Code 1 pulses it for one clock at the start of every second line, together with `hsync_o`.
- R7: Code 2 pulses `sc_rst_o` together with `vsync_o` when `field_seq_o` (a 3-bit field count cleared by sync) is 0, which is every 8 fields. Code 3 pulses it when `field_seq_o[1:0]` is 0, which is every 4 fields.
- R8: `blank_o` follows mode bit 1.
- R9: After reset, all configuration fields are 0. `h_cnt_o`, `half_line_o`, `field_o`, `vsync_o`, `sc_rst_o` and `blank_o` are 0.
- R10: Writes to address 3 change no setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 2 | Register address (0 trigger low, 1 trigger high/vertical, 2 mode) |
| cfg_wdata_i | input | 8 | Register write data |
| ext_sync_i | input | 1 | External sync pulse, realigns both counters |
| h_cnt_o | output | H_W | Pixel position within the line |
| half_line_o | output | V_W | Half-line position within the field |
| field_o | output | 1 | Interlace field parity |
| field_seq_o | output | 3 | Field count modulo 8 since the last sync |
| hsync_o | output | 1 | High at pixel 0 of each line |
| vsync_o | output | 1 | One-clock field-start strobe |
| sc_rst_o | output | 1 | Subcarrier phase-reset pulse |
| blank_o | output | 1 | Forced blanking flag |

## Verification
The assertions check, on every cycle, the local rules of the counters and strobes. The pixel counter either steps by one or wraps to zero. The half-line count holds between half-line boundaries. A progressive field never starts with parity 1. The subcarrier pulse is one clock wide and coincides with the strobe of its cadence. Only the bench scenarios can show the global figures: the clock counts per line and per field for every field code at both rates, the interlaced alternation of start position, the trigger delays including clamping and the vertical sign, and the spacing of the subcarrier pulses.

// File: rtl/etg_pkg.sv
package etg_pkg;
  typedef enum logic [1:0] {
    SCR_OFF   = 2'd0,
    SCR_2LINE = 2'd1,
    SCR_8FLD  = 2'd2,
    SCR_4FLD  = 2'd3
  } scr_mode_e;

  typedef enum logic [1:0] {
    FL_ILACE  = 2'd0,
    FL_SHORT  = 2'd1,
    FL_LONG_A = 2'd2,
    FL_LONG_B = 2'd3
  } flen_e;

  typedef struct packed {
    logic [10:0] htrig;
    logic [4:0]  vtrig;
    logic        vneg;
    logic        blank;
    flen_e       flen;
    scr_mode_e   scm;
    logic        rate60;
  } cfg_t;

  localparam logic [1:0] ADDR_HLO  = 2'd0;
  localparam logic [1:0] ADDR_HHI  = 2'd1;
  localparam logic [1:0] ADDR_MODE = 2'd2;
endpackage

// File: rtl/etg_regs.sv
module etg_regs
  import etg_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic [1:0] addr_i,
  input  logic [7:0] wdata_i,
  output cfg_t       cfg_o
);
  cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q.htrig  <= '0;
      cfg_q.vtrig  <= '0;
      cfg_q.vneg   <= 1'b0;
      cfg_q.blank  <= 1'b0;
      cfg_q.flen   <= FL_ILACE;
      cfg_q.scm    <= SCR_OFF;
      cfg_q.rate60 <= 1'b0;
    end else if (we_i) begin
      unique case (addr_i)
        ADDR_HLO: cfg_q.htrig[7:0] <= wdata_i;
        ADDR_HHI: begin
          cfg_q.htrig[10:8] <= wdata_i[2:0];
          cfg_q.vtrig       <= wdata_i[7:3];
        end
        ADDR_MODE: begin
          cfg_q.vneg   <= wdata_i[0];
          cfg_q.blank  <= wdata_i[1];
          cfg_q.flen   <= flen_e'(wdata_i[3:2]);
          cfg_q.scm    <= scr_mode_e'(wdata_i[5:4]);
          cfg_q.rate60 <= wdata_i[6];
        end
        default: ;  // address 3 unused
      endcase
    end
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/etg_hcnt.sv
module etg_hcnt #(
  parameter int H_W = 11
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           sync_i,
  input  logic [H_W-1:0] line_len_i,
  input  logic [H_W-1:0] load_i,
  output logic [H_W-1:0] cnt_o,
  output logic           end_o,
  output logic           mid_o
);
  logic [H_W-1:0] cnt_q;

  // >= so a shorter line selected mid-line still wraps
  assign end_o = cnt_q >= line_len_i - 1'b1;
  assign mid_o = cnt_q == (line_len_i >> 1) - 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (sync_i)  cnt_q <= load_i;
    else if (end_o)   cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/etg_vcnt.sv
module etg_vcnt #(
  parameter int V_W = 10
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           sync_i,
  input  logic           bnd_i,
  input  logic           ilace_i,
  input  logic [V_W-1:0] fld_len_i,
  input  logic [V_W-1:0] load_i,
  output logic [V_W-1:0] hl_o,
  output logic           vs_o,
  output logic           field_o,
  output logic [2:0]     fseq_o
);
  logic [V_W-1:0] hl_q;
  logic           vs_q, field_q;
  logic [2:0]     fseq_q;
  logic           wrap;

  assign wrap = bnd_i && (hl_q >= fld_len_i - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hl_q    <= '0;
      vs_q    <= 1'b0;
      field_q <= 1'b0;
      fseq_q  <= '0;
    end else if (sync_i) begin
      hl_q    <= load_i;
      vs_q    <= load_i == '0;
      field_q <= 1'b0;
      fseq_q  <= '0;
    end else if (wrap) begin
      hl_q    <= '0;
      vs_q    <= 1'b1;
      field_q <= ilace_i ? ~field_q : 1'b0;
      fseq_q  <= fseq_q + 1'b1;
    end else begin
      vs_q <= 1'b0;
      if (bnd_i) hl_q <= hl_q + 1'b1;
    end
  end

  assign hl_o    = hl_q;
  assign vs_o    = vs_q;
  assign field_o = field_q;
  assign fseq_o  = fseq_q;
endmodule

// File: rtl/etg_scr.sv
module etg_scr
  import etg_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      sync_i,
  input  logic      hend_i,
  input  logic      hsync_i,
  input  logic      vsync_i,
  input  logic [2:0] fseq_i,
  input  scr_mode_e mode_i,
  output logic      pulse_o
);
  logic lpar_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      lpar_q <= 1'b0;
    else if (sync_i)  lpar_q <= 1'b0;
    else if (hend_i)  lpar_q <= ~lpar_q;
  end

  always_comb begin
    unique case (mode_i)
      SCR_2LINE: pulse_o = hsync_i && !lpar_q;
      SCR_8FLD:  pulse_o = vsync_i && (fseq_i == 3'd0);
      SCR_4FLD:  pulse_o = vsync_i && (fseq_i[1:0] == 2'd0);
      default:   pulse_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/enc_timing_gen.sv
module enc_timing_gen
  import etg_pkg::*;
#(
  parameter int LINE_50  = 1728,
  parameter int LINE_60  = 1716,
  parameter int LINES_50 = 312,
  parameter int LINES_60 = 262,
  localparam int LMAX = (LINE_50 > LINE_60) ? LINE_50 : LINE_60,
  localparam int NMAX = (LINES_50 > LINES_60) ? LINES_50 : LINES_60,
  localparam int H_W  = $clog2(LMAX + 1),
  localparam int V_W  = $clog2(2 * NMAX + 3)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           cfg_we_i,
  input  logic [1:0]     cfg_addr_i,
  input  logic [7:0]     cfg_wdata_i,
  input  logic           ext_sync_i,
  output logic [H_W-1:0] h_cnt_o,
  output logic [V_W-1:0] half_line_o,
  output logic           field_o,
  output logic [2:0]     field_seq_o,
  output logic           hsync_o,
  output logic           vsync_o,
  output logic           sc_rst_o,
  output logic           blank_o
);
  localparam int HTW = (H_W > 11) ? H_W : 11;
  localparam int VTW = (V_W > 5) ? V_W : 5;

  cfg_t           cfg;
  logic [H_W-1:0] line_len_w, h_load;
  logic [V_W-1:0] lines_w, fld_len_w, vt_eff, v_load;
  logic [1:0]     scm_w, flen_w;
  logic           hend, hmid;

  etg_regs i_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (cfg_we_i),
    .addr_i (cfg_addr_i),
    .wdata_i(cfg_wdata_i),
    .cfg_o  (cfg)
  );

  always_comb begin
    line_len_w = cfg.rate60 ? H_W'(LINE_60) : H_W'(LINE_50);
    lines_w    = cfg.rate60 ? V_W'(LINES_60) : V_W'(LINES_50);
    unique case (cfg.flen)
      FL_ILACE: fld_len_w = (lines_w << 1) + V_W'(1);
      FL_SHORT: fld_len_w = lines_w << 1;
      default:  fld_len_w = (lines_w << 1) + V_W'(2);
    endcase
    // trigger values clamp to the last legal position
    h_load = (HTW'(cfg.htrig) > HTW'(line_len_w) - HTW'(1))
           ? line_len_w - 1'b1 : H_W'(cfg.htrig);
    vt_eff = (VTW'(cfg.vtrig) > VTW'(fld_len_w) - VTW'(1))
           ? fld_len_w - 1'b1 : V_W'(cfg.vtrig);
    v_load = (cfg.vneg && vt_eff != '0) ? fld_len_w - vt_eff : vt_eff;
  end

  assign scm_w  = cfg.scm;
  assign flen_w = cfg.flen;

  etg_hcnt #(.H_W(H_W)) i_hcnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sync_i    (ext_sync_i),
    .line_len_i(line_len_w),
    .load_i    (h_load),
    .cnt_o     (h_cnt_o),
    .end_o     (hend),
    .mid_o     (hmid)
  );

  etg_vcnt #(.V_W(V_W)) i_vcnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sync_i   (ext_sync_i),
    .bnd_i    (hend || hmid),
    .ilace_i  (cfg.flen == FL_ILACE),
    .fld_len_i(fld_len_w),
    .load_i   (v_load),
    .hl_o     (half_line_o),
    .vs_o     (vsync_o),
    .field_o  (field_o),
    .fseq_o   (field_seq_o)
  );

  assign hsync_o = h_cnt_o == '0;

  etg_scr i_scr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sync_i (ext_sync_i),
    .hend_i (hend),
    .hsync_i(hsync_o),
    .vsync_i(vsync_o),
    .fseq_i (field_seq_o),
    .mode_i (cfg.scm),
    .pulse_o(sc_rst_o)
  );

  assign blank_o = cfg.blank;
endmodule

// File: rtl/etg_chk.sv
module etg_chk #(
  parameter int H_W = 11,
  parameter int V_W = 10
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           ext_sync_i,
  input logic [H_W-1:0] h_cnt_o,
  input logic [H_W-1:0] line_len_w,
  input logic [V_W-1:0] half_line_o,
  input logic           field_o,
  input logic           hsync_o,
  input logic           vsync_o,
  input logic           sc_rst_o,
  input logic [1:0]     scm_w,
  input logic [1:0]     flen_w
);
  a_r1_h_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ext_sync_i |=> (h_cnt_o == $past(h_cnt_o) + 1'b1) || (h_cnt_o == '0));

  a_r2_hl_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ext_sync_i && (h_cnt_o < line_len_w - 1'b1)
      && (h_cnt_o != (line_len_w >> 1) - 1'b1) |=> $stable(half_line_o));

  a_r3_prog_parity: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vsync_o && ($past(flen_w) != 2'd0) |-> !field_o);

  a_r6_sc_one_wide: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sc_rst_o |=> !sc_rst_o);

  a_r6_sc_line: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sc_rst_o && (scm_w == 2'd1) |-> hsync_o);

  a_r7_sc_field: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sc_rst_o && scm_w[1] |-> vsync_o);

  a_r6_sc_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scm_w == 2'd0) |-> !sc_rst_o);
endmodule

bind enc_timing_gen etg_chk #(.H_W(H_W), .V_W(V_W)) i_etg_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ext_sync_i (ext_sync_i),
  .h_cnt_o    (h_cnt_o),
  .line_len_w (line_len_w),
  .half_line_o(half_line_o),
  .field_o    (field_o),
  .hsync_o    (hsync_o),
  .vsync_o    (vsync_o),
  .sc_rst_o   (sc_rst_o),
  .scm_w      (scm_w),
  .flen_w     (flen_w)
);

// File: tb/test_enc_timing_gen.sv
module test_enc_timing_gen;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int L50 = 24, L60 = 20, N50 = 8, N60 = 6;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       we = 1'b0, ext_sync = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;

  logic [4:0]  h_cnt, half_line;
  logic        field, hsync, vsync, sc_rst, blank;
  logic [2:0]  fseq;
  logic [10:0] h_cnt_f;
  logic [9:0]  half_line_f;
  logic        field_f, hsync_f, vsync_f, sc_rst_f, blank_f;
  logic [2:0]  fseq_f;

  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  enc_timing_gen #(.LINE_50(L50), .LINE_60(L60), .LINES_50(N50), .LINES_60(N60))
  i_enc_timing_gen (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(we), .cfg_addr_i(addr),
    .cfg_wdata_i(wdata), .ext_sync_i(ext_sync), .h_cnt_o(h_cnt),
    .half_line_o(half_line), .field_o(field), .field_seq_o(fseq),
    .hsync_o(hsync), .vsync_o(vsync), .sc_rst_o(sc_rst), .blank_o(blank)
  );

  enc_timing_gen i_enc_timing_gen_full (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(we), .cfg_addr_i(addr),
    .cfg_wdata_i(wdata), .ext_sync_i(ext_sync), .h_cnt_o(h_cnt_f),
    .half_line_o(half_line_f), .field_o(field_f), .field_seq_o(fseq_f),
    .hsync_o(hsync_f), .vsync_o(vsync_f), .sc_rst_o(sc_rst_f), .blank_o(blank_f)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  function automatic logic [7:0] mode(input bit r60, input int scm, input int fl,
                                      input bit blk, input bit vn);
    return {1'b0, r60, 2'(scm), 2'(fl), blk, vn};
  endfunction

  function automatic bit sig(input int sel);
    case (sel)
      0: return hsync;
      1: return vsync;
      2: return sc_rst;
      default: return hsync_f;
    endcase
  endfunction

  task automatic sync_pulse();
    @(negedge clk); ext_sync = 1'b1;
    @(negedge clk); ext_sync = 1'b0;
  endtask

  // clocks from one pulse of sel to the next
  task automatic period(input int sel, output int p);
    int n = 0;
    while (!sig(sel) && n < 20000) begin @(negedge clk); n++; end
    p = 0;
    do begin @(negedge clk); p++; end while (!sig(sel) && p < 20000);
  endtask

  // count from capturing edge (=1) to first sample of sel
  task automatic trig_delay(input int sel, output int n);
    sync_pulse();
    n = 1;
    while (!sig(sel) && n < 5000) begin @(negedge clk); n++; end
  endtask

  task automatic t_reset();
    check("R9 h_cnt", int'(h_cnt), 0);
    check("R9 half_line", int'(half_line), 0);
    check("R9 field", int'(field), 0);
    check("R9 vsync", int'(vsync), 0);
    check("R9 sc_rst", int'(sc_rst), 0);
    check("R9 blank", int'(blank), 0);
  endtask

  task automatic t_line_len();
    int p;
    wr(2'd2, mode(0, 0, 1, 0, 0));
    period(3, p); check("R1 full 50Hz line", p, 1728);
    period(0, p); check("R1 50Hz line", p, L50);
    wr(2'd2, mode(1, 0, 1, 0, 0));
    period(3, p); check("R1 full 60Hz line", p, 1716);
    period(0, p); check("R1 60Hz line", p, L60);
  endtask

  task automatic t_field(input bit r60, input int fl);
    int p, h0, h1, f0, f1, n, len, fld;
    string tag;
    n   = r60 ? N60 : N50;
    len = r60 ? L60 : L50;
    fld = (fl == 0) ? 2*n+1 : (fl == 1) ? 2*n : 2*n+2;
    wr(2'd2, mode(r60, 0, fl, 0, 0));
    sync_pulse();
    period(1, p);
    h0 = int'(h_cnt); f0 = int'(field);
    period(1, p);
    h1 = int'(h_cnt); f1 = int'(field);
    tag = $sformatf("rate60=%0d code=%0d", r60, fl);
    check({"R2 field clocks ", tag}, p, fld * len / 2);
    if (fl == 0) begin
      check({"R3 parity toggles ", tag}, int'(f0 != f1), 1);
      check({"R3 half-line offset ", tag}, (h0 > h1) ? h0 - h1 : h1 - h0, len / 2);
    end else begin
      check({"R3 parity low ", tag}, f0 + f1, 0);
      check({"R3 same start ", tag}, h1, h0);
    end
  endtask

  task automatic t_htrig();
    int n;
    wr(2'd2, mode(0, 0, 1, 0, 0));
    wr(2'd1, 8'h00);
    wr(2'd0, 8'd0);  trig_delay(0, n); check("R4 htrig 0", n, 1);
    wr(2'd0, 8'd5);  trig_delay(0, n); check("R4 htrig 5", n, 1 + L50 - 5);
    wr(2'd0, 8'd23); trig_delay(0, n); check("R4 htrig last", n, 2);
    wr(2'd0, 8'hD0); wr(2'd1, 8'h07);  // 2000, beyond line
    trig_delay(0, n); check("R4 htrig clamp", n, 2);
  endtask

  task automatic t_vtrig();
    int n;
    wr(2'd0, 8'd23);                   // pixel loads L50-1
    wr(2'd2, mode(0, 0, 1, 0, 0));     // F = 16
    wr(2'd1, 8'h00); trig_delay(1, n); check("R5 vtrig 0", n, 1);
    wr(2'd1, 8'd3 << 3); trig_delay(1, n); check("R5 vtrig +3", n, 2 + 12*12);
    wr(2'd2, mode(0, 0, 1, 0, 1));
    trig_delay(1, n); check("R5 vtrig -3", n, 2 + 2*12);
    wr(2'd2, mode(0, 0, 1, 0, 0));
    wr(2'd1, 8'd31 << 3); trig_delay(1, n); check("R5 vtrig clamp", n, 2);
  endtask

  task automatic t_scr();
    int p, cnt;
    wr(2'd0, 8'd0); wr(2'd1, 8'h00);
    wr(2'd2, mode(0, 1, 1, 0, 0));
    sync_pulse();
    period(2, p); check("R6 two-line cadence", p, 2 * L50);
    check("R6 pulse on hsync", int'(hsync), 1);
    wr(2'd2, mode(0, 3, 1, 0, 0));
    sync_pulse();
    period(2, p); check("R7 four-field cadence", p, 4 * 16 * L50 / 2);
    check("R7 pulse on vsync", int'(vsync), 1);
    wr(2'd2, mode(0, 2, 1, 0, 0));
    sync_pulse();
    period(2, p); check("R7 eight-field cadence", p, 8 * 16 * L50 / 2);
    check("R7 field seq zero", int'(fseq), 0);
    wr(2'd2, mode(0, 0, 1, 0, 0));
    cnt = 0;
    repeat (2000) begin @(negedge clk); cnt += int'(sc_rst); end
    check("R6 mode off silent", cnt, 0);
  endtask

  task automatic t_blank_and_map();
    int p;
    wr(2'd2, mode(0, 0, 1, 1, 0));
    check("R8 blank set", int'(blank), 1);
    wr(2'd2, mode(0, 0, 1, 0, 0));
    check("R8 blank clear", int'(blank), 0);
    wr(2'd3, 8'hFF);
    check("R10 addr3 blank", int'(blank), 0);
    period(0, p); check("R10 addr3 rate", p, L50);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_line_len();
    t_field(0, 0); t_field(0, 1); t_field(0, 2); t_field(0, 3);
    t_field(1, 0); t_field(1, 1); t_field(1, 2);
    t_htrig();
    t_vtrig();
    t_scr();
    t_blank_and_map();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule